// File: doc/BRIEF.md
# K-means Cluster Assignment Engine

This block runs one pass of k-means clustering over a stream of multispectral pixels. Each pixel carries several spectral bands. For every pixel the engine measures the L1 distance (sum of absolute band differences) to each stored cluster center. It labels the pixel with the nearest cluster and adds the pixel's band values into that cluster's running sums and pixel count.

A host first writes the starting centers through a load port. It then streams pixels with a valid/acknowledge handshake and closes the pass with an end-of-iteration pulse. The engine waits for the pipeline to drain. It then divides each band sum by its cluster's count with a sequential divider and writes the quotients back as the new centers. After that it clears the sums and counts and pulses a done flag. The host can then stream the next pass. The centers can be read back through a registered read port.

Top module: `kmeans_assign`

## Requirements
- R1: After reset, `px_ack` is 1, `class_valid` and `iter_done` are 0, every center is 0, and `rd_value` is 0.
- R2: Each accepted pixel gets the class whose center has the smallest L1 distance to it: the sum over all bands of |pixel band − center band|. Band b of a pixel or center is bits [b*COMP_W +: COMP_W] of the bus and is unsigned.
- R3: When two or more clusters are at the same minimum distance, the lowest-numbered one is chosen.
- R4: A pixel is accepted on a rising edge where `px_valid` and `px_ack` are both 1. Its `class_valid`/`class_id` become visible after the second rising edge that follows the accepting edge. Classes leave in acceptance order.
- R5: From the cycle after `iter_end` until `iter_done` has pulsed, `px_ack` is 0, and pixels offered in that window produce no class output.
- R6: A rising edge with `ld_valid` high writes `ld_value` into band `ld_band` of center `ld_cluster`. Pixels accepted afterwards are measured against the new center.
- R7: After `iter_end`, each center band of a cluster with n > 0 assigned pixels becomes floor(sum of that band over those pixels / n).
- R8: A cluster with no assigned pixels in the pass keeps its previous center.
- R9: `iter_done` is a one-cycle pulse after every center has been processed. Sums and counts are then empty, so the next pass averages only its own pixels.
- R10: `rd_value` shows band `rd_band` of center `rd_cluster` one rising edge after those inputs are applied.
- R11: Per-cluster sums and counts hold up to 2^CNT_W − 1 pixels of full-scale value without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Center write strobe from host |
| ld_cluster | input | CIDX_W | Cluster index to write |
| ld_band | input | BIDX_W | Band index to write |
| ld_value | input | COMP_W | Center band value |
| px_valid | input | 1 | Pixel present |
| px_data | input | NUM_BANDS*COMP_W | Pixel bands, band b at [b*COMP_W +: COMP_W] |
| px_ack | output | 1 | Engine accepts pixels this cycle |
| iter_end | input | 1 | Pulse after the last pixel of a pass |
| class_valid | output | 1 | Class result valid |
| class_id | output | CIDX_W | Nearest cluster index |
| iter_done | output | 1 | One-cycle pulse when the center update is complete |
| rd_cluster | input | CIDX_W | Center read cluster index |
| rd_band | input | BIDX_W | Center read band index |
| rd_value | output | COMP_W | Registered center band value |

## Verification
The assertions take several things for granted about the host. Center loads arrive only while the engine is in its streaming phase with an empty pipeline. `iter_end` is raised only in the streaming phase. No cluster collects more than 2^CNT_W − 1 pixels in one pass. The divider is never started with a zero count.

The stimulus stays within these limits. It loads every center before the first pixel and pulses `iter_end` only after the last pixel has been handed over. It sends at most a handful of pixels per pass. Pixels offered while the engine is updating centers are offered only to confirm that they are refused.

// File: rtl/kmeans_pkg.sv
package kmeans_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_DRAIN = 3'd1,
    ST_PICK  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_FIN   = 3'd4
  } ctrl_state_t;

endpackage

// File: rtl/kmeans_distance.sv
module kmeans_distance #(
  parameter int NUM_CLUSTERS = 5,
  parameter int NUM_BANDS    = 4,
  parameter int COMP_W       = 12,
  localparam int CIDX_W = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1,
  localparam int DIST_W = COMP_W + $clog2(NUM_BANDS) + 1,
  localparam int PIX_W  = NUM_BANDS * COMP_W,
  localparam int CTR_W  = NUM_CLUSTERS * NUM_BANDS * COMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [CTR_W-1:0]  ctr_flat,
  output logic              out_vld,
  output logic [CIDX_W-1:0] out_cls,
  output logic [PIX_W-1:0]  out_pix,
  output logic              busy
);

  // stage 1: per-band absolute differences
  logic [COMP_W-1:0] ad_q [NUM_CLUSTERS][NUM_BANDS];
  logic [PIX_W-1:0]  pix1_q;
  logic              v1_q;
  // stage 2: per-cluster distance
  logic [DIST_W-1:0] dist_q [NUM_CLUSTERS];
  logic [PIX_W-1:0]  pix2_q;
  logic              v2_q;
  // stage 3: selected class
  logic [CIDX_W-1:0] cls_q;
  logic [PIX_W-1:0]  pix3_q;
  logic              v3_q;

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CLUSTERS; c++) begin
      for (int b = 0; b < NUM_BANDS; b++) begin
        if (in_pix[b*COMP_W +: COMP_W] >= ctr_flat[(c*NUM_BANDS+b)*COMP_W +: COMP_W])
          ad_q[c][b] <= in_pix[b*COMP_W +: COMP_W] - ctr_flat[(c*NUM_BANDS+b)*COMP_W +: COMP_W];
        else
          ad_q[c][b] <= ctr_flat[(c*NUM_BANDS+b)*COMP_W +: COMP_W] - in_pix[b*COMP_W +: COMP_W];
      end
    end
    pix1_q <= in_pix;
  end

  logic [DIST_W-1:0] dsum [NUM_CLUSTERS];
  always_comb begin
    for (int c = 0; c < NUM_CLUSTERS; c++) begin
      dsum[c] = '0;
      for (int b = 0; b < NUM_BANDS; b++)
        dsum[c] = dsum[c] + DIST_W'(ad_q[c][b]);
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CLUSTERS; c++)
      dist_q[c] <= dsum[c];
    pix2_q <= pix1_q;
  end

  // linear scan with strict compare keeps the lowest index on ties
  logic [DIST_W-1:0] best_d;
  logic [CIDX_W-1:0] best_i;
  always_comb begin
    best_d = dist_q[0];
    best_i = '0;
    for (int c = 1; c < NUM_CLUSTERS; c++) begin
      if (dist_q[c] < best_d) begin
        best_d = dist_q[c];
        best_i = CIDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    cls_q  <= best_i;
    pix3_q <= pix2_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_vld;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  assign out_vld = v3_q;
  assign out_cls = cls_q;
  assign out_pix = pix3_q;
  assign busy    = v1_q | v2_q | v3_q;

  for (genvar gc = 0; gc < NUM_CLUSTERS; gc++) begin : g_win
    for (genvar gj = 0; gj < NUM_CLUSTERS; gj++) begin : g_rival
      if (gj < gc) begin : g_lo
        AST_TIE_LOWEST: assert property (@(posedge clk) disable iff (rst)
          (v3_q && cls_q == CIDX_W'(gc)) |-> ($past(dist_q[gj]) > $past(dist_q[gc]))); // R3
      end else if (gj > gc) begin : g_hi
        AST_NEAREST: assert property (@(posedge clk) disable iff (rst)
          (v3_q && cls_q == CIDX_W'(gc)) |-> ($past(dist_q[gj]) >= $past(dist_q[gc]))); // R2
      end
    end
  end

endmodule

// File: rtl/kmeans_accum.sv
module kmeans_accum #(
  parameter int NUM_CLUSTERS = 5,
  parameter int NUM_BANDS    = 4,
  parameter int COMP_W       = 12,
  parameter int CNT_W        = 20,
  localparam int CIDX_W = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1,
  localparam int BIDX_W = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1,
  localparam int ACC_W  = COMP_W + CNT_W,
  localparam int PIX_W  = NUM_BANDS * COMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_vld,
  input  logic [CIDX_W-1:0] in_cls,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [CIDX_W-1:0] rd_cls,
  input  logic [BIDX_W-1:0] rd_band,
  output logic [ACC_W-1:0]  rd_sum,
  output logic [CNT_W-1:0]  rd_cnt
);

  logic [ACC_W-1:0] sum_q [NUM_CLUSTERS][NUM_BANDS];
  logic [CNT_W-1:0] cnt_q [NUM_CLUSTERS];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int c = 0; c < NUM_CLUSTERS; c++) begin
        cnt_q[c] <= '0;
        for (int b = 0; b < NUM_BANDS; b++)
          sum_q[c][b] <= '0;
      end
    end else if (in_vld) begin
      cnt_q[in_cls] <= cnt_q[in_cls] + CNT_W'(1);
      for (int b = 0; b < NUM_BANDS; b++)
        sum_q[in_cls][b] <= sum_q[in_cls][b] + ACC_W'(in_pix[b*COMP_W +: COMP_W]);
    end
  end

  assign rd_sum = sum_q[rd_cls][rd_band];
  assign rd_cnt = cnt_q[rd_cls];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !clr) |-> (cnt_q[in_cls] != '1)); // R11

endmodule

// File: rtl/kmeans_divider.sv
module kmeans_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 20,
  localparam int STEP_W = $clog2(NUM_W + 1),
  localparam int PROD_W = NUM_W + DEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);

  logic [NUM_W-1:0]  num_q;
  logic [DEN_W-1:0]  den_q;
  logic [DEN_W-1:0]  rem_q;
  logic [NUM_W-1:0]  quo_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q;
  logic              done_q;

  logic [DEN_W:0] shifted;
  logic [DEN_W:0] diff;
  logic           fits;
  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    diff    = shifted - {1'b0, den_q};
    fits    = shifted >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        num_q  <= num;
        den_q  <= den;
        quo_q  <= num;
        rem_q  <= '0;
        step_q <= STEP_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
        quo_q  <= {quo_q[NUM_W-2:0], fits};
        step_q <= step_q - STEP_W'(1);
        if (step_q == STEP_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = quo_q;

  logic [PROD_W-1:0] prod;
  assign prod = PROD_W'(quo_q) * PROD_W'(den_q);

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ((prod <= PROD_W'(num_q)) && ((PROD_W'(num_q) - prod) < PROD_W'(den_q)))); // R7
  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
    start |-> (den != '0)); // R8

endmodule

// File: rtl/kmeans_assign.sv
module kmeans_assign #(
  parameter int NUM_CLUSTERS = 5,
  parameter int NUM_BANDS    = 4,
  parameter int COMP_W       = 12,
  parameter int CNT_W        = 20,
  localparam int CIDX_W = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1,
  localparam int BIDX_W = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1,
  localparam int ACC_W  = COMP_W + CNT_W,
  localparam int PIX_W  = NUM_BANDS * COMP_W,
  localparam int CTR_W  = NUM_CLUSTERS * NUM_BANDS * COMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [CIDX_W-1:0] ld_cluster,
  input  logic [BIDX_W-1:0] ld_band,
  input  logic [COMP_W-1:0] ld_value,
  input  logic              px_valid,
  input  logic [PIX_W-1:0]  px_data,
  output logic              px_ack,
  input  logic              iter_end,
  output logic              class_valid,
  output logic [CIDX_W-1:0] class_id,
  output logic              iter_done,
  input  logic [CIDX_W-1:0] rd_cluster,
  input  logic [BIDX_W-1:0] rd_band,
  output logic [COMP_W-1:0] rd_value
);
  import kmeans_pkg::*;

  ctrl_state_t       st_q;
  logic [CIDX_W-1:0] sel_c_q;
  logic [BIDX_W-1:0] sel_b_q;
  logic              done_q;
  logic [COMP_W-1:0] rd_q;

  logic [COMP_W-1:0] ctr_q [NUM_CLUSTERS][NUM_BANDS];
  logic [CTR_W-1:0]  ctr_flat;

  logic              pipe_busy;
  logic              cls_vld;
  logic [CIDX_W-1:0] cls_id;
  logic [PIX_W-1:0]  cls_pix;
  logic [ACC_W-1:0]  acc_sum;
  logic [CNT_W-1:0]  acc_cnt;
  logic              acc_clr;
  logic              div_start;
  logic              div_busy;
  logic              div_done;
  logic [ACC_W-1:0]  div_quo;
  logic              accept;
  logic              last_slot;

  always_comb begin
    for (int c = 0; c < NUM_CLUSTERS; c++)
      for (int b = 0; b < NUM_BANDS; b++)
        ctr_flat[(c*NUM_BANDS+b)*COMP_W +: COMP_W] = ctr_q[c][b];
  end

  assign px_ack    = (st_q == ST_RUN);
  assign accept    = px_valid && px_ack;
  assign acc_clr   = (st_q == ST_FIN);
  assign div_start = (st_q == ST_PICK) && (acc_cnt != '0);
  assign last_slot = (sel_c_q == CIDX_W'(NUM_CLUSTERS-1)) && (sel_b_q == BIDX_W'(NUM_BANDS-1));

  kmeans_distance #(
    .NUM_CLUSTERS(NUM_CLUSTERS), .NUM_BANDS(NUM_BANDS), .COMP_W(COMP_W)
  ) u_distance (
    .clk(clk), .rst(rst), .in_vld(accept), .in_pix(px_data), .ctr_flat(ctr_flat),
    .out_vld(cls_vld), .out_cls(cls_id), .out_pix(cls_pix), .busy(pipe_busy)
  );

  kmeans_accum #(
    .NUM_CLUSTERS(NUM_CLUSTERS), .NUM_BANDS(NUM_BANDS), .COMP_W(COMP_W), .CNT_W(CNT_W)
  ) u_accum (
    .clk(clk), .rst(rst), .clr(acc_clr), .in_vld(cls_vld), .in_cls(cls_id), .in_pix(cls_pix),
    .rd_cls(sel_c_q), .rd_band(sel_b_q), .rd_sum(acc_sum), .rd_cnt(acc_cnt)
  );

  kmeans_divider #(.NUM_W(ACC_W), .DEN_W(CNT_W)) u_divider (
    .clk(clk), .rst(rst), .start(div_start), .num(acc_sum), .den(acc_cnt),
    .busy(div_busy), .done(div_done), .quo(div_quo)
  );

  // control sequence: stream, drain, walk every (cluster, band) slot, clear
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_RUN;
      sel_c_q <= '0;
      sel_b_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (st_q == ST_FIN);
      unique case (st_q)
        ST_RUN: begin
          if (iter_end) st_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!pipe_busy) begin
            st_q    <= ST_PICK;
            sel_c_q <= '0;
            sel_b_q <= '0;
          end
        end
        ST_PICK, ST_WAIT: begin
          if ((st_q == ST_PICK && acc_cnt == '0) || (st_q == ST_WAIT && div_done)) begin
            if (last_slot) begin
              st_q <= ST_FIN;
            end else begin
              st_q <= ST_PICK;
              if (sel_b_q == BIDX_W'(NUM_BANDS-1)) begin
                sel_b_q <= '0;
                sel_c_q <= sel_c_q + CIDX_W'(1);
              end else begin
                sel_b_q <= sel_b_q + BIDX_W'(1);
              end
            end
          end else if (st_q == ST_PICK) begin
            st_q <= ST_WAIT;
          end
        end
        ST_FIN: begin
          st_q <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  // center store: divider result has priority over host load
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CLUSTERS; c++)
        for (int b = 0; b < NUM_BANDS; b++)
          ctr_q[c][b] <= '0;
    end else if (div_done) begin
      ctr_q[sel_c_q][sel_b_q] <= div_quo[COMP_W-1:0];
    end else if (ld_valid && int'(ld_cluster) < NUM_CLUSTERS) begin
      ctr_q[ld_cluster][ld_band] <= ld_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else if (int'(rd_cluster) < NUM_CLUSTERS)
      rd_q <= ctr_q[rd_cluster][rd_band];
    else
      rd_q <= '0;
  end

  assign class_valid = cls_vld;
  assign class_id    = cls_id;
  assign iter_done   = done_q;
  assign rd_value    = rd_q;

  AST_EMPTY_KEEPS: assert property (@(posedge clk) disable iff (rst)
    div_done |-> (acc_cnt != '0)); // R8
  AST_MEAN_FITS: assert property (@(posedge clk) disable iff (rst)
    div_done |-> (div_quo[ACC_W-1:COMP_W] == '0)); // R7
  AST_DIV_IDLE_PICK: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PICK) |-> !div_busy); // R7
  AST_END_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    iter_end |-> (st_q == ST_RUN)); // R5
  AST_NO_ACK_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    iter_end |=> !px_ack); // R5
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> ((st_q == ST_RUN) && !pipe_busy)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    iter_done |=> !iter_done); // R9

endmodule

// File: tb/kmeans_assign_bench.sv
module kmeans_assign_bench;

  localparam int NC = 5;
  localparam int NB = 4;
  localparam int CW = 12;
  localparam int NPIX = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic [2:0]    ld_cluster = '0;
  logic [1:0]    ld_band = '0;
  logic [11:0]   ld_value = '0;
  logic          px_valid = 1'b0;
  logic [47:0]   px_data = '0;
  logic          px_ack;
  logic          iter_end = 1'b0;
  logic          class_valid;
  logic [2:0]    class_id;
  logic          iter_done;
  logic [2:0]    rd_cluster = '0;
  logic [1:0]    rd_band = '0;
  logic [11:0]   rd_value;

  always #2 clk = ~clk;

  kmeans_assign u_kmeans_assign (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_cluster(ld_cluster), .ld_band(ld_band),
    .ld_value(ld_value), .px_valid(px_valid), .px_data(px_data), .px_ack(px_ack),
    .iter_end(iter_end), .class_valid(class_valid), .class_id(class_id),
    .iter_done(iter_done), .rd_cluster(rd_cluster), .rd_band(rd_band), .rd_value(rd_value)
  );

  // stimulus table: bands listed {b3,b2,b1,b0}; initial centers are all-k*1000
  localparam logic [47:0] PIX_TAB [NPIX] = '{
    {12'd40,   12'd30,   12'd20,   12'd10},    // near 0
    {12'd1000, 12'd1000, 12'd900,  12'd1100},  // near 1
    {12'd500,  12'd500,  12'd500,  12'd500},   // tie 0/1 -> 0
    {12'd1500, 12'd1500, 12'd1500, 12'd1500},  // tie 1/2 -> 1
    {12'd4095, 12'd4095, 12'd4095, 12'd4095},  // full scale -> 4 (R11)
    {12'd2990, 12'd3000, 12'd3000, 12'd3000},  // near 3
    {12'd4095, 12'd0,    12'd4095, 12'd0},     // five-way tie -> 0
    {12'd1950, 12'd2050, 12'd1900, 12'd2100}   // near 2
  };
  localparam int CLS_TAB [NPIX] = '{0, 1, 0, 1, 4, 3, 0, 2};
  localparam bit TIE_TAB [NPIX] = '{0, 0, 1, 1, 0, 0, 1, 0};

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  int n_exp = 0;
  int n_got = 0;
  int exp_cls [64];
  bit exp_tie [64];
  int acc_cyc [64];
  int ctr_m [NC][NB];
  int sm [NC][NB];
  int ct [NC];

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_cls(logic [47:0] p);
    int best = 0;
    int bd = -1;
    for (int c = 0; c < NC; c++) begin
      int d = 0;
      for (int b = 0; b < NB; b++) begin
        int df = int'(p[b*CW +: CW]) - ctr_m[c][b];
        d += (df < 0) ? -df : df;
      end
      if (bd < 0 || d < bd) begin
        bd = d;
        best = c;
      end
    end
    return best;
  endfunction

  // monitor: class order, value and latency
  always @(negedge clk) begin
    if (!rst && class_valid) begin
      if (n_got < n_exp) begin
        if (exp_tie[n_got])
          check(int'(class_id) == exp_cls[n_got], "R3 tie class", int'(class_id), exp_cls[n_got]);
        else
          check(int'(class_id) == exp_cls[n_got], "R2 nearest class", int'(class_id), exp_cls[n_got]);
        check(cyc - acc_cyc[n_got] == 2, "R4 latency", cyc - acc_cyc[n_got], 2);
      end else begin
        check(1'b0, "R5 unexpected class output", int'(class_id), -1);
      end
      n_got++;
    end
  end

  task automatic send(logic [47:0] p, int cls, bit tie);
    px_valid = 1'b1;
    px_data  = p;
    exp_cls[n_exp] = cls;
    exp_tie[n_exp] = tie;
    n_exp++;
    ct[cls]++;
    for (int b = 0; b < NB; b++) sm[cls][b] += int'(p[b*CW +: CW]);
    @(negedge clk);
    acc_cyc[n_exp-1] = cyc;
  endtask

  task automatic load(int c, int b, int v);
    ld_valid = 1'b1;
    ld_cluster = 3'(c);
    ld_band = 2'(b);
    ld_value = 12'(v);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic rd_chk(int c, int b, int exp, string tag);
    rd_cluster = 3'(c);
    rd_band = 2'(b);
    @(negedge clk);
    check(int'(rd_value) == exp, tag, int'(rd_value), exp);
  endtask

  task automatic finish_pass(bit second);
    bit seen = 1'b0;
    px_valid = 1'b0;
    iter_end = 1'b1;
    @(negedge clk);
    iter_end = 1'b0;
    check(px_ack == 1'b0, "R5 ack low after end", int'(px_ack), 0);
    // offer a pixel while updating; it must be refused
    px_valid = 1'b1;
    px_data = {4{12'd7}};
    repeat (4) @(negedge clk);
    check(px_ack == 1'b0, "R5 ack low during update", int'(px_ack), 0);
    px_valid = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (iter_done) begin
        seen = 1'b1;
        break;
      end
    end
    check(seen, "R9 done pulse seen", int'(seen), 1);
    @(negedge clk);
    check(iter_done == 1'b0, "R9 done lasts one cycle", int'(iter_done), 0);
    check(px_ack == 1'b1, "R5 ack back after done", int'(px_ack), 1);
    check(n_got == n_exp, "R5 classified count", n_got, n_exp);
    for (int c = 0; c < NC; c++) begin
      for (int b = 0; b < NB; b++) begin
        if (ct[c] > 0) begin
          ctr_m[c][b] = sm[c][b] / ct[c];
          rd_chk(c, b, ctr_m[c][b], second ? "R7 R9 mean of second pass" : "R7 mean");
        end else begin
          rd_chk(c, b, ctr_m[c][b], "R8 empty cluster keeps center");
        end
        sm[c][b] = 0;
      end
      ct[c] = 0;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      ct[c] = 0;
      for (int b = 0; b < NB; b++) begin
        sm[c][b] = 0;
        ctr_m[c][b] = 0;
      end
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd_cluster = 3'd2;
    rd_band = 2'd3;
    @(negedge clk);
    // R1 reset state
    check(px_ack == 1'b1, "R1 ack after reset", int'(px_ack), 1);
    check(class_valid == 1'b0, "R1 class_valid after reset", int'(class_valid), 0);
    check(iter_done == 1'b0, "R1 done after reset", int'(iter_done), 0);
    check(rd_value == '0, "R1 center zero after reset", int'(rd_value), 0);

    // R6 host load, R10 readback
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) begin
        ctr_m[c][b] = c * 1000;
        load(c, b, c * 1000);
      end
    for (int c = 0; c < NC; c++)
      rd_chk(c, c % NB, c * 1000, "R6 R10 loaded center");

    // pass 1: table walk, back to back
    for (int i = 0; i < NPIX; i++)
      send(PIX_TAB[i], CLS_TAB[i], TIE_TAB[i]);
    px_valid = 1'b0;
    finish_pass(1'b0);

    // pass 2: gapped stream against updated centers; some clusters stay empty (R8)
    begin
      logic [47:0] p2 [4];
      p2[0] = {4{12'd0}};
      p2[1] = {4{12'd4095}};
      p2[2] = {4{12'd1250}};
      p2[3] = {12'd5, 12'd3, 12'd2, 12'd1};
      for (int i = 0; i < 4; i++) begin
        send(p2[i], model_cls(p2[i]), 1'b0);
        px_valid = 1'b0;
        @(negedge clk);
      end
    end
    finish_pass(1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule